// File: doc/BRIEF.md
# Multi-Mode Asynchronous Serial Port

This block is a full-duplex asynchronous serial transmitter and receiver for a single port. Frames carry a low start bit, eight or nine data bits sent least-significant bit first, and a high stop bit. The frame length and the baud source depend on a two-bit mode. One mode uses 8-bit frames timed by an external baud enable. A second uses 9-bit frames with the baud rate fixed at the system clock divided by 32 or 64. A third uses 9-bit frames timed by the external enable. Mode code 0 leaves both directions idle. In 9-bit frames the transmitted ninth bit is a constant 0, a constant 1, even parity or odd parity.

Software sees one data-buffer location. A write starts a transmit frame, and a read consumes the receive buffer. The receiver oversamples every bit sixteen times and decides each bit by a majority vote of three samples at mid-bit. A start edge that does not hold at mid-bit is discarded. A holding register behind the receive buffer keeps a second complete word while software still holds the first. A low stop bit raises a framing-error flag. The transmit-done and receive-done flags stay set until software clears them.

Top module: `uart_core`

## Requirements
- R1: `txd_o` idles high. A transmit frame is a 0 start bit, then the data bits with bit 0 first, then a 1 stop bit. In mode 1 (`mode_i`=1) the frame has 8 data bits, so it is 10 bits long.
- R2: In modes 2 and 3 the frame has 9 data bits, and the ninth bit follows `ninth_sel_i`: 0 gives constant 0, 1 gives constant 1, 2 gives the XOR of the 8 data bits (even parity), and 3 gives its inverse (odd parity).
- R3: In mode 2 one bit lasts 32 clocks when `slow_div_i`=0 and 64 clocks when `slow_div_i`=1. In modes 1 and 3 one bit lasts 16 pulses of `baud_tick_i`.
- R4: `txdone_o` sets when the stop bit begins and stays set until a `clr_txdone_i` pulse. `tx_busy_o` is high from the cycle after the accepted write until the stop bit ends.
- R5: A write to the data buffer is ignored while `tx_busy_o` is high or while `mode_i`=0.
- R6: The receiver samples each bit at oversample ticks 7, 8 and 9 of 16 and takes the majority. `buf_rdata_o` returns the 8 data bits. `rx_bit8_o` returns the received ninth bit in modes 2 and 3 and the sampled stop bit in mode 1. `rxdone_o` sets when a word enters the receive buffer.
- R7: A low pulse on `rxd_i` that has ended before mid-bit starts no frame and sets no flag.
- R8: A stop bit that is sampled low sets `frame_err_o`. A `clr_rxdone_i` pulse clears both `rxdone_o` and `frame_err_o`.
- R9: A word that completes while the buffer is still unread goes to a holding register. A read (`buf_rd_i`) then moves it into the buffer and sets `rxdone_o` again. A word that arrives while both are full is discarded. An unread buffer keeps its value.
- R10: When `rx_en_i`=0 or `mode_i`=0, no new receive frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 0 idle, 1 8-bit external tick, 2 9-bit fixed divide, 3 9-bit external tick |
| slow_div_i | input | 1 | Fixed divide select: 0 for /32, 1 for /64 |
| ninth_sel_i | input | 2 | Ninth transmit bit: 0, 1, even parity, odd parity |
| rx_en_i | input | 1 | Receiver enable |
| baud_tick_i | input | 1 | External 16x oversample enable |
| buf_wr_i | input | 1 | Data-buffer write strobe |
| buf_wdata_i | input | 8 | Data-buffer write value |
| buf_rd_i | input | 1 | Data-buffer read strobe |
| buf_rdata_o | output | 8 | Receive buffer contents |
| clr_txdone_i | input | 1 | Clear transmit-done flag |
| clr_rxdone_i | input | 1 | Clear receive-done and framing-error flags |
| txdone_o | output | 1 | Transmit-done flag |
| rxdone_o | output | 1 | Receive-done flag |
| rx_bit8_o | output | 1 | Ninth received bit of the buffered word |
| frame_err_o | output | 1 | Framing-error flag |
| tx_busy_o | output | 1 | Transmit frame in progress |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |

## Verification
The assertions assume that `mode_i`, `slow_div_i` and `ninth_sel_i` stay fixed while a frame is in flight, and that `baud_tick_i` pulses for single cycles. The bench changes these settings only while both lines are idle. It drives the external tick from a free-running counter. It drives `rxd_i` with whole bit periods, apart from the deliberately short start glitch and the shortened bad stop bit.

// File: rtl/uart_pkg.sv
package uart_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_8EXT = 2'd1,
        MODE_9FIX = 2'd2,
        MODE_9EXT = 2'd3
    } uart_mode_e;

    typedef enum logic [1:0] {
        NB_ZERO = 2'd0,
        NB_ONE  = 2'd1,
        NB_EVEN = 2'd2,
        NB_ODD  = 2'd3
    } ninth_sel_e;

    typedef struct packed {
        logic [7:0] data;
        logic       bit8;
        logic       ferr;
    } rx_word_t;

    function automatic logic ninth_bit(input ninth_sel_e sel, input logic [7:0] d);
        case (sel)
            NB_ZERO: return 1'b0;
            NB_ONE:  return 1'b1;
            NB_EVEN: return ^d;
            default: return ~^d;
        endcase
    endfunction

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/uart_baud.sv
module uart_baud #(
    parameter int OVERSAMPLE = 16,
    parameter int DIV_FAST   = 32,
    parameter int DIV_SLOW   = 64
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic [1:0] mode_i,
    input  logic       slow_div_i,
    input  logic       ext_tick_i,
    output logic       os_tick_o
);
    import uart_pkg::*;

    localparam int PRE_FAST = DIV_FAST / OVERSAMPLE;
    localparam int PRE_SLOW = DIV_SLOW / OVERSAMPLE;
    localparam int CW       = $clog2(PRE_SLOW + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;
    logic          fix_tick;

    assign lim      = slow_div_i ? CW'(PRE_SLOW - 1) : CW'(PRE_FAST - 1);
    assign fix_tick = (cnt_q >= lim);

    always_ff @(posedge clk_i) begin
        if (rst_i || fix_tick) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        case (uart_mode_e'(mode_i))
            MODE_OFF:  os_tick_o = 1'b0;
            MODE_9FIX: os_tick_o = fix_tick;
            default:   os_tick_o = ext_tick_i;
        endcase
    end

endmodule

// File: rtl/uart_tx.sv
module uart_tx #(
    parameter int OVERSAMPLE = 16
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       en_i,
    input  logic       nine_i,
    input  logic       os_tick_i,
    input  logic       load_i,
    input  logic [7:0] data_i,
    input  logic       bit8_i,
    output logic       txd_o,
    output logic       busy_o,
    output logic       stop_start_o
);
    localparam int PW   = $clog2(OVERSAMPLE);
    localparam int LAST = OVERSAMPLE - 1;

    logic [10:0]   shreg_q;
    logic [3:0]    left_q;
    logic [PW-1:0] phase_q;
    logic          busy_q;
    logic          bit_end;

    assign bit_end = busy_q && os_tick_i && (phase_q == PW'(LAST));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            shreg_q <= '1;
            left_q  <= '0;
            phase_q <= '0;
            busy_q  <= 1'b0;
        end else if (!busy_q) begin
            if (load_i && en_i) begin
                shreg_q <= nine_i ? {1'b1, bit8_i, data_i, 1'b0}
                                  : {2'b11, data_i, 1'b0};
                left_q  <= nine_i ? 4'd11 : 4'd10;
                phase_q <= '0;
                busy_q  <= 1'b1;
            end
        end else if (os_tick_i) begin
            phase_q <= (phase_q == PW'(LAST)) ? '0 : phase_q + 1'b1;
            if (bit_end) begin
                shreg_q <= {1'b1, shreg_q[10:1]};
                left_q  <= left_q - 1'b1;
                if (left_q == 4'd1) busy_q <= 1'b0;
            end
        end
    end

    assign stop_start_o = bit_end && (left_q == 4'd2);
    assign txd_o        = busy_q ? shreg_q[0] : 1'b1;
    assign busy_o       = busy_q;

endmodule

// File: rtl/uart_rx.sv
module uart_rx #(
    parameter int OVERSAMPLE = 16
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               en_i,
    input  logic               nine_i,
    input  logic               os_tick_i,
    input  logic               rxd_i,
    output logic               done_o,
    output uart_pkg::rx_word_t word_o
);
    import uart_pkg::*;

    localparam int PW   = $clog2(OVERSAMPLE);
    localparam int LAST = OVERSAMPLE - 1;
    localparam int MID  = OVERSAMPLE / 2 + 1;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

    rx_state_e     st_q;
    logic [1:0]    sync_q;
    logic          rx_s;
    logic [PW-1:0] cnt_q;
    logic [1:0]    votes_q;
    logic [3:0]    bitn_q;
    logic [8:0]    sh_q;
    logic          vote;
    logic          at_mid;
    logic          at_last;

    assign rx_s    = sync_q[1];
    assign vote    = maj3(votes_q[1], votes_q[0], rx_s);
    assign at_mid  = (cnt_q == PW'(MID));
    assign at_last = (cnt_q == PW'(LAST));

    always_ff @(posedge clk_i) begin
        if (rst_i) sync_q <= 2'b11;
        else       sync_q <= {sync_q[0], rxd_i};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q    <= RX_IDLE;
            cnt_q   <= '0;
            votes_q <= '0;
            bitn_q  <= '0;
            sh_q    <= '0;
            done_o  <= 1'b0;
            word_o  <= '0;
        end else begin
            done_o <= 1'b0;
            if (os_tick_i) begin
                if (st_q == RX_IDLE) begin
                    if (en_i && !rx_s) begin
                        st_q  <= RX_START;
                        cnt_q <= '0;
                    end
                end else begin
                    cnt_q <= at_last ? '0 : cnt_q + 1'b1;
                    if (cnt_q == PW'(MID - 2) || cnt_q == PW'(MID - 1))
                        votes_q <= {votes_q[0], rx_s};
                    case (st_q)
                        RX_START: begin
                            if (at_mid && vote) st_q <= RX_IDLE;
                            else if (at_last) begin
                                st_q   <= RX_DATA;
                                bitn_q <= '0;
                            end
                        end
                        RX_DATA: begin
                            if (at_mid) sh_q <= {vote, sh_q[8:1]};
                            if (at_last) begin
                                bitn_q <= bitn_q + 1'b1;
                                if (bitn_q == (nine_i ? 4'd8 : 4'd7)) st_q <= RX_STOP;
                            end
                        end
                        RX_STOP: begin
                            if (at_mid) begin
                                done_o      <= 1'b1;
                                word_o.data <= nine_i ? sh_q[7:0] : sh_q[8:1];
                                word_o.bit8 <= nine_i ? sh_q[8] : vote;
                                word_o.ferr <= !vote;
                                st_q        <= RX_IDLE;
                            end
                        end
                        default: st_q <= RX_IDLE;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/uart_core.sv
module uart_core #(
    parameter int OVERSAMPLE = 16,
    parameter int DIV_FAST   = 32,
    parameter int DIV_SLOW   = 64
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic [1:0] mode_i,
    input  logic       slow_div_i,
    input  logic [1:0] ninth_sel_i,
    input  logic       rx_en_i,
    input  logic       baud_tick_i,
    input  logic       buf_wr_i,
    input  logic [7:0] buf_wdata_i,
    input  logic       buf_rd_i,
    output logic [7:0] buf_rdata_o,
    input  logic       clr_txdone_i,
    input  logic       clr_rxdone_i,
    output logic       txdone_o,
    output logic       rxdone_o,
    output logic       rx_bit8_o,
    output logic       frame_err_o,
    output logic       tx_busy_o,
    input  logic       rxd_i,
    output logic       txd_o
);
    import uart_pkg::*;

    logic     os_tick;
    logic     active;
    logic     nine;
    logic     stop_start;
    logic     rx_done;
    rx_word_t rx_word;

    rx_word_t buf_q, buf_n, pend_q, pend_n;
    logic     buf_full, full_n, pend_v_q, pend_v_n, ld;
    logic     rxdone_q, ferr_q, txdone_q;

    assign active = (uart_mode_e'(mode_i) != MODE_OFF);
    assign nine   = mode_i[1];

    uart_baud #(.OVERSAMPLE(OVERSAMPLE), .DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) baud_i (
        .clk_i(clk_i), .rst_i(rst_i), .mode_i(mode_i), .slow_div_i(slow_div_i),
        .ext_tick_i(baud_tick_i), .os_tick_o(os_tick)
    );

    uart_tx #(.OVERSAMPLE(OVERSAMPLE)) tx_i (
        .clk_i(clk_i), .rst_i(rst_i), .en_i(active), .nine_i(nine), .os_tick_i(os_tick),
        .load_i(buf_wr_i), .data_i(buf_wdata_i),
        .bit8_i(ninth_bit(ninth_sel_e'(ninth_sel_i), buf_wdata_i)),
        .txd_o(txd_o), .busy_o(tx_busy_o), .stop_start_o(stop_start)
    );

    uart_rx #(.OVERSAMPLE(OVERSAMPLE)) rx_i (
        .clk_i(clk_i), .rst_i(rst_i), .en_i(active && rx_en_i), .nine_i(nine),
        .os_tick_i(os_tick), .rxd_i(rxd_i), .done_o(rx_done), .word_o(rx_word)
    );

    always_comb begin
        buf_n    = buf_q;
        full_n   = buf_full;
        pend_n   = pend_q;
        pend_v_n = pend_v_q;
        ld       = 1'b0;
        if (buf_rd_i && buf_full) begin
            if (pend_v_q) begin
                buf_n    = pend_q;
                pend_v_n = 1'b0;
                ld       = 1'b1;
            end else begin
                full_n = 1'b0;
            end
        end
        if (rx_done) begin
            if (!full_n) begin
                buf_n  = rx_word;
                full_n = 1'b1;
                ld     = 1'b1;
            end else if (!pend_v_n) begin
                pend_n   = rx_word;
                pend_v_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            buf_q    <= '0;
            buf_full <= 1'b0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
            rxdone_q <= 1'b0;
            ferr_q   <= 1'b0;
            txdone_q <= 1'b0;
        end else begin
            buf_q    <= buf_n;
            buf_full <= full_n;
            pend_q   <= pend_n;
            pend_v_q <= pend_v_n;
            if (ld)                rxdone_q <= 1'b1;
            else if (clr_rxdone_i) rxdone_q <= 1'b0;
            if (rx_done && rx_word.ferr) ferr_q <= 1'b1;
            else if (clr_rxdone_i)       ferr_q <= 1'b0;
            if (stop_start)        txdone_q <= 1'b1;
            else if (clr_txdone_i) txdone_q <= 1'b0;
        end
    end

    assign buf_rdata_o = buf_q.data;
    assign rx_bit8_o   = buf_q.bit8;
    assign rxdone_o    = rxdone_q;
    assign frame_err_o = ferr_q;
    assign txdone_o    = txdone_q;

endmodule

// File: rtl/uart_core_chk.sv
module uart_core_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic [1:0] mode_i,
    input logic       buf_wr_i,
    input logic       buf_rd_i,
    input logic       clr_txdone_i,
    input logic       tx_busy_o,
    input logic       txd_o,
    input logic       txdone_o,
    input logic       rxdone_o,
    input logic [7:0] buf_rdata_o,
    input logic       buf_full
);
    // R1
    tx_idle_high_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !tx_busy_o |-> txd_o);

    // R4
    txdone_in_frame_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(txdone_o) |-> tx_busy_o);

    // R4
    txdone_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (clr_txdone_i && !tx_busy_o) |=> !txdone_o);

    // R5
    mode_off_no_tx_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (buf_wr_i && mode_i == 2'd0 && !tx_busy_o) |=> !tx_busy_o);

    // R9
    rx_buf_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (buf_full && !buf_rd_i) |=> $stable(buf_rdata_o));

    // R6
    rxdone_with_word_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(rxdone_o) |-> buf_full);
endmodule

bind uart_core uart_core_chk chk_i (
    .clk_i(clk_i), .rst_i(rst_i), .mode_i(mode_i), .buf_wr_i(buf_wr_i),
    .buf_rd_i(buf_rd_i), .clr_txdone_i(clr_txdone_i), .tx_busy_o(tx_busy_o),
    .txd_o(txd_o), .txdone_o(txdone_o), .rxdone_o(rxdone_o),
    .buf_rdata_o(buf_rdata_o), .buf_full(buf_full)
);

// File: tb/uart_core_tb_top.sv
`timescale 1ns/1ps
module uart_core_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'd2;
    logic       slow_div = 1'b0;
    logic [1:0] ninth_sel = 2'd0;
    logic       rx_en = 1'b1;
    logic       baud_tick = 1'b0;
    logic       buf_wr = 1'b0;
    logic [7:0] buf_wdata = 8'h00;
    logic       buf_rd = 1'b0;
    logic [7:0] buf_rdata;
    logic       clr_txdone = 1'b0;
    logic       clr_rxdone = 1'b0;
    logic       txdone, rxdone, rx_bit8, frame_err, tx_busy, txd;
    logic       rxd = 1'b1;

    int errors = 0;
    int checks = 0;
    int tick_cnt = 0;
    localparam int EXT_DIV = 3;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        tick_cnt  <= (tick_cnt == EXT_DIV - 1) ? 0 : tick_cnt + 1;
        baud_tick <= (tick_cnt == EXT_DIV - 1);
    end

    uart_core dut_i (
        .clk_i(clk), .rst_i(rst), .mode_i(mode), .slow_div_i(slow_div),
        .ninth_sel_i(ninth_sel), .rx_en_i(rx_en), .baud_tick_i(baud_tick),
        .buf_wr_i(buf_wr), .buf_wdata_i(buf_wdata), .buf_rd_i(buf_rd),
        .buf_rdata_o(buf_rdata), .clr_txdone_i(clr_txdone), .clr_rxdone_i(clr_rxdone),
        .txdone_o(txdone), .rxdone_o(rxdone), .rx_bit8_o(rx_bit8),
        .frame_err_o(frame_err), .tx_busy_o(tx_busy), .rxd_i(rxd), .txd_o(txd)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    function automatic logic exp_ninth(input logic [1:0] sel, input logic [7:0] d);
        case (sel)
            2'd0: return 1'b0;
            2'd1: return 1'b1;
            2'd2: return ^d;
            default: return ~^d;
        endcase
    endfunction

    function automatic int bit_clocks();
        if (mode == 2'd2) return slow_div ? 64 : 32;
        return 16 * EXT_DIV;
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_buf(input logic [7:0] d);
        buf_wdata = d; buf_wr = 1'b1; cyc(1); buf_wr = 1'b0;
    endtask

    task automatic pulse_rd();
        buf_rd = 1'b1; cyc(1); buf_rd = 1'b0;
    endtask

    task automatic pulse_clr();
        clr_rxdone = 1'b1; clr_txdone = 1'b1; cyc(1); clr_rxdone = 1'b0; clr_txdone = 1'b0;
    endtask

    task automatic capture(input int nbits, output logic [10:0] cap);
        int bc = bit_clocks();
        int guard = 0;
        cap = '1;
        while (txd !== 1'b0 && guard < 2000) begin cyc(1); guard++; end
        cyc(bc / 2);
        for (int i = 0; i < nbits; i++) begin
            cap[i] = txd;
            if (i < nbits - 1) cyc(bc);
        end
    endtask

    task automatic send(input logic [8:0] d, input int ndata, input bit good_stop);
        int bc = bit_clocks();
        rxd = 1'b0; cyc(bc);
        for (int i = 0; i < ndata; i++) begin rxd = d[i]; cyc(bc); end
        if (good_stop) begin rxd = 1'b1; cyc(bc); end
        else begin rxd = 1'b0; cyc(bc * 3 / 4); rxd = 1'b1; cyc(bc); end
        cyc(4);
    endtask

    task automatic wait_idle();
        int g = 0;
        while (tx_busy && g < 2000) begin cyc(1); g++; end
        cyc(2);
    endtask

    task automatic measure_low(output int len);
        int g = 0;
        len = 0;
        while (txd !== 1'b0 && g < 2000) begin cyc(1); g++; end
        while (txd !== 1'b1 && g < 4000) begin cyc(1); g++; end
        while (txd !== 1'b0 && g < 6000) begin cyc(1); g++; end
        while (txd === 1'b0 && g < 8000) begin cyc(1); len++; g++; end
    endtask

    initial begin
        cyc(200000);
        check(1'b0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        logic [10:0] cap;
        logic [7:0] d;
        logic [8:0] w;
        logic [7:0] da, db, dc;
        int len;
        void'($urandom(32'd1234));
        cyc(5);
        rst = 1'b0;
        cyc(2);
        // R1 R4 reset state
        check(txd === 1'b1 && !tx_busy, "R1 reset idle line", {txd, tx_busy}, 2'b10);
        check(!txdone && !rxdone && !frame_err, "R4 reset flags", {txdone, rxdone, frame_err}, 0);

        // R1 R2 R4: 9-bit frames, fixed divide, every ninth-bit choice
        mode = 2'd2;
        for (int i = 0; i < 8; i++) begin
            d = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'($urandom);
            ninth_sel = 2'(i % 4);
            write_buf(d);
            capture(11, cap);
            check(cap == {1'b1, exp_ninth(ninth_sel, d), d, 1'b0}, "R2 nine-bit frame",
                  cap, {1'b1, exp_ninth(ninth_sel, d), d, 1'b0});
            check(txdone === 1'b1, "R4 txdone at stop", txdone, 1);
            wait_idle();
            check(txdone === 1'b1, "R4 txdone held", txdone, 1);
            pulse_clr();
            check(txdone === 1'b0, "R4 txdone cleared", txdone, 0);
        end

        // R5 write while busy ignored
        write_buf(8'hA5);
        cyc(6);
        write_buf(8'h3C);
        capture(11, cap);
        check(cap[8:1] == 8'hA5, "R5 busy write ignored", cap[8:1], 8'hA5);
        wait_idle(); pulse_clr();

        // R5 mode 0 write ignored
        mode = 2'd0;
        write_buf(8'h12);
        cyc(5);
        check(!tx_busy && txd === 1'b1, "R5 mode0 write ignored", {tx_busy, txd}, 2'b01);

        // R3 bit lengths
        mode = 2'd2; slow_div = 1'b0;
        write_buf(8'h55); measure_low(len);
        check(len == 32, "R3 divide 32", len, 32);
        wait_idle();
        slow_div = 1'b1;
        write_buf(8'h55); measure_low(len);
        check(len == 64, "R3 divide 64", len, 64);
        wait_idle();
        mode = 2'd3;
        write_buf(8'h55); measure_low(len);
        check(len == 16 * EXT_DIV, "R3 external tick", len, 16 * EXT_DIV);
        wait_idle(); pulse_clr();

        // R1 8-bit frame with external tick
        mode = 2'd1;
        for (int i = 0; i < 3; i++) begin
            d = 8'($urandom);
            write_buf(d);
            capture(10, cap);
            check(cap[9:0] == {1'b1, d, 1'b0}, "R1 eight-bit frame", cap[9:0], {1'b1, d, 1'b0});
            wait_idle();
        end
        pulse_clr();

        // R6 receive, 9-bit external tick
        mode = 2'd3;
        for (int i = 0; i < 4; i++) begin
            w = 9'($urandom);
            send(w, 9, 1'b1);
            check(rxdone === 1'b1 && buf_rdata == w[7:0] && rx_bit8 == w[8] && !frame_err,
                  "R6 nine-bit receive", {rxdone, frame_err, rx_bit8, buf_rdata},
                  {2'b10, w[8], w[7:0]});
            pulse_rd(); pulse_clr();
        end

        // R6 receive, 8-bit, bit8 holds stop
        mode = 2'd1;
        w = {1'b0, 8'($urandom)};
        send(w, 8, 1'b1);
        check(rxdone === 1'b1 && buf_rdata == w[7:0] && rx_bit8 === 1'b1, "R6 eight-bit receive",
              {rxdone, rx_bit8, buf_rdata}, {2'b11, w[7:0]});
        pulse_rd(); pulse_clr();

        // R8 framing error
        mode = 2'd2; slow_div = 1'b0;
        send(9'h0C3, 9, 1'b0);
        check(frame_err === 1'b1 && rxdone === 1'b1, "R8 framing error", {frame_err, rxdone}, 2'b11);
        cyc(40);
        pulse_rd(); pulse_clr();
        check(frame_err === 1'b0 && rxdone === 1'b0, "R8 flags cleared", {frame_err, rxdone}, 0);

        // R7 start glitch
        rxd = 1'b0; cyc(4); rxd = 1'b1; cyc(32 * 12);
        check(rxdone === 1'b0 && frame_err === 1'b0, "R7 glitch rejected", {rxdone, frame_err}, 0);

        // R9 double buffer
        da = 8'($urandom); db = 8'($urandom); dc = ~db;
        send({1'b1, da}, 9, 1'b1);
        send({1'b0, db}, 9, 1'b1);
        send({1'b1, dc}, 9, 1'b1);
        check(rxdone === 1'b1 && buf_rdata == da, "R9 first word kept", buf_rdata, da);
        pulse_clr();
        pulse_rd();
        check(rxdone === 1'b1 && buf_rdata == db && rx_bit8 === 1'b0, "R9 held word moved",
              {rxdone, buf_rdata}, {1'b1, db});
        pulse_clr();
        pulse_rd();
        cyc(3);
        check(rxdone === 1'b0 && buf_rdata == db, "R9 third word dropped", {rxdone, buf_rdata}, {1'b0, db});

        // R10 receiver disabled
        rx_en = 1'b0;
        send(9'h1A5, 9, 1'b1);
        check(rxdone === 1'b0, "R10 rx_en low", rxdone, 0);
        rx_en = 1'b1; mode = 2'd0;
        send(9'h1A5, 9, 1'b1);
        check(rxdone === 1'b0, "R10 mode0 rx", rxdone, 0);

        summary();
    end
endmodule